// File: doc/BRIEF.md
# Control-Transfer Sequencer for an 8-bit Accumulator CPU

This block runs the multi-cycle control-transfer instructions of a classic 8-bit accumulator processor: subroutine call and return, return from interrupt, software break, jump through a pointer, and the stack pushes and pulls of the accumulator and the flags. It also runs the two instructions that set or clear the interrupt-disable bit. It owns the 16-bit program counter, the 8-bit stack pointer and the status register. It makes exactly one access per cycle on a single 8-bit data bus with a 16-bit address. The idle reads and stack reads that real hardware performs are reproduced in order.

An outer fetch unit reads the opcode, leaves the program counter on the byte after it, and pulses `start_i` with an operation code. The sequencer then drives the bus until `done_o` marks the final cycle. Memory returns read data in the same cycle it sees the address. The stack lives in a fixed page. A push writes `{page, SP}` and then decrements SP. A pull first increments SP and then reads `{page, SP}`. Whenever an instruction changes the interrupt-disable bit through a flag pull or a set/clear, the block raises a marker that stays up until the next instruction retires. An interrupt controller uses this marker to delay recognition by one instruction.

Top module: `cts_seq_top`

## Requirements
- R1: After reset the program counter is 0x0400, the stack pointer is 0xFD and the status register is 0x24. The block is idle, with no read or write strobe.
- R2: At most one of rd_o and we_o is high in any cycle, and neither is high while idle. done_o is high only on the last cycle. Cycle counts are: call 5, return 5, interrupt return 5, break 6, pointer jump 4, push 2, pull 3, set/clear of the mask 1.
- R3: Operation codes: 0 call, 1 return, 2 interrupt return, 3 break, 4 pointer jump, 5 push accumulator, 6 push flags, 7 pull accumulator, 8 pull flags, 9 set mask, 10 clear mask. Every stack access uses page 0x01. A push writes {0x01,SP} and then decrements SP. A pull reads {0x01,SP+1} and leaves SP incremented.
- R4: Call: read target low at PC, idle stack read, push PC high, push PC low (PC now points at the target high byte), read target high, load PC.
- R5: Return: idle read at PC, idle stack read, pop low, pop high, idle read at the popped address, and then PC becomes the popped address plus one.
- R6: Interrupt return: idle read at PC, idle stack read, pop flags, pop PC low, pop PC high. The popped PC is used unchanged.
- R7: Break: idle read at PC, with PC advanced by one to skip the padding byte. It then pushes PC high, PC low and the flags. The interrupt-disable bit (bit 2) is set, and PC is loaded from 0xFFFE (low byte) and 0xFFFF (high byte).
- R8: Pointer jump reads a two-byte pointer at PC. It takes the target low byte from the pointer. It takes the target high byte from the pointer's page with the low byte plus one, wrapped inside that page.
- R9: A pushed status byte has bits 4 and 5 set. When flags are pulled, bit 4 is stored as 0 and bit 5 as 1, whatever the popped byte holds.
- R10: Pulling the accumulator pulses acc_we_o with the popped byte on acc_o on the final cycle. It sets N (bit 7) from bit 7 of the byte and Z (bit 1) when the byte is zero.
- R11: At the end of a flag pull, set mask or clear mask, irq_off_o is raised if the disable bit went 0 to 1 and irq_on_o if it went 1 to 0. Any other retiring instruction clears both. They are never high together.
- R12: start_i is ignored while an instruction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the operation on op_i (accepted when idle) |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value for a push |
| rdata_i | input | 8 | Read data, valid in the cycle of the address |
| addr_o | output | 16 | Bus address |
| rd_o | output | 1 | Read strobe |
| we_o | output | 1 | Write strobe |
| wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Final cycle of the instruction |
| acc_o | output | 8 | Pulled accumulator value |
| acc_we_o | output | 1 | Accumulator write enable |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status register |
| irq_off_o | output | 1 | Interrupts just became disabled |
| irq_on_o | output | 1 | Interrupts just became enabled |

## Verification
The assertions assume that memory answers a read in the same cycle as the address. They also assume that op_i holds one of the eleven defined codes whenever start_i is accepted. The stimulus meets this by modelling memory as a combinational array indexed by the low 12 address bits. It drives only defined codes, and it raises start_i during a busy instruction only in the test that checks that start_i is ignored. The stack page, the pointer pages and the break vector land on distinct words of that array, so the page-wrap read can be told apart from a carried read.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int STEP_W = 3;

  localparam int ST_C = 0;
  localparam int ST_Z = 1;
  localparam int ST_I = 2;
  localparam int ST_B = 4;
  localparam int ST_U = 5;
  localparam int ST_N = 7;

  typedef enum logic [3:0] {
    OP_CALL  = 4'd0,
    OP_RET   = 4'd1,
    OP_RETI  = 4'd2,
    OP_BRK   = 4'd3,
    OP_JMPI  = 4'd4,
    OP_PUSHA = 4'd5,
    OP_PUSHF = 4'd6,
    OP_PULLA = 4'd7,
    OP_PULLF = 4'd8,
    OP_SETI  = 4'd9,
    OP_CLRI  = 4'd10
  } op_e;

  typedef enum logic [3:0] {
    AK_NONE, AK_PC, AK_STK, AK_PUSH, AK_POP, AK_VLO, AK_VHI, AK_PLO, AK_PHI
  } acc_kind_e;

  typedef enum logic [1:0] {PD_PCH, PD_PCL, PD_FLG, PD_ACC} push_sel_e;

  typedef struct packed {
    acc_kind_e kind;
    push_sel_e psel;
  } bus_step_t;

  function automatic logic [STEP_W-1:0] last_step(op_e op);
    case (op)
      OP_CALL, OP_RET, OP_RETI: return 3'd4;
      OP_BRK:                   return 3'd5;
      OP_JMPI:                  return 3'd3;
      OP_PUSHA, OP_PUSHF:       return 3'd1;
      OP_PULLA, OP_PULLF:       return 3'd2;
      default:                  return 3'd0;
    endcase
  endfunction

  function automatic bus_step_t decode_step(op_e op, logic [STEP_W-1:0] st);
    bus_step_t r;
    r.kind = AK_NONE;
    r.psel = PD_ACC;
    if (st == 3'd0 && op <= OP_CLRI) r.kind = AK_PC;
    case (op)
      OP_CALL: case (st)
        3'd1: r.kind = AK_STK;
        3'd2: begin r.kind = AK_PUSH; r.psel = PD_PCH; end
        3'd3: begin r.kind = AK_PUSH; r.psel = PD_PCL; end
        3'd4: r.kind = AK_PC;
        default: ;
      endcase
      OP_RET: case (st)
        3'd1: r.kind = AK_STK;
        3'd2, 3'd3: r.kind = AK_POP;
        3'd4: r.kind = AK_PC;
        default: ;
      endcase
      OP_RETI: case (st)
        3'd1: r.kind = AK_STK;
        3'd2, 3'd3, 3'd4: r.kind = AK_POP;
        default: ;
      endcase
      OP_BRK: case (st)
        3'd1: begin r.kind = AK_PUSH; r.psel = PD_PCH; end
        3'd2: begin r.kind = AK_PUSH; r.psel = PD_PCL; end
        3'd3: begin r.kind = AK_PUSH; r.psel = PD_FLG; end
        3'd4: r.kind = AK_VLO;
        3'd5: r.kind = AK_VHI;
        default: ;
      endcase
      OP_JMPI: case (st)
        3'd1: r.kind = AK_PC;
        3'd2: r.kind = AK_PLO;
        3'd3: r.kind = AK_PHI;
        default: ;
      endcase
      OP_PUSHA: if (st == 3'd1) r.kind = AK_PUSH;
      OP_PUSHF: if (st == 3'd1) begin r.kind = AK_PUSH; r.psel = PD_FLG; end
      OP_PULLA, OP_PULLF: case (st)
        3'd1: r.kind = AK_STK;
        3'd2: r.kind = AK_POP;
        default: ;
      endcase
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cts_ctrl.sv
module cts_ctrl
  import cts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  output logic              busy_o,
  output op_e               op_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o,
  output acc_kind_e         kind_o,
  output push_sel_e         psel_o
);
  localparam logic [STEP_W-1:0] STEP_ONE = 1;

  logic              busy_q;
  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  bus_step_t         cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_CALL;
      step_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        op_q   <= op_i;
        step_q <= '0;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else begin
      step_q <= step_q + STEP_ONE;
    end
  end

  assign done_o = busy_q && (step_q == last_step(op_q));
  assign cur    = decode_step(op_q, step_q);
  assign kind_o = busy_q ? cur.kind : AK_NONE;
  assign psel_o = cur.psel;
  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign step_o = step_q;

  AST_DONE_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o) else $error("done did not retire"); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (busy_o && op_o == $past(op_o))) else $error("op changed mid-flight"); // R12
  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> step_o <= last_step(op_o)) else $error("step overrun"); // R2
endmodule

// File: rtl/cts_agu.sv
module cts_agu
  import cts_pkg::*;
#(
  parameter int                 DATA_W     = 8,
  parameter logic [DATA_W-1:0]  STACK_PAGE = 8'h01,
  parameter logic [2*DATA_W-1:0] VEC_ADDR  = 16'hFFFE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  acc_kind_e           kind_i,
  input  push_sel_e           psel_i,
  input  logic [2*DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0]   sp_i,
  input  logic [2*DATA_W-1:0] ptr_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [DATA_W-1:0]   st_i,
  output logic [2*DATA_W-1:0] addr_o,
  output logic                rd_o,
  output logic                we_o,
  output logic [DATA_W-1:0]   wdata_o
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] B_ONE = 1;
  localparam logic [ADDR_W-1:0] W_ONE = 1;

  logic [DATA_W-1:0] push_flags;

  always_comb begin
    push_flags       = st_i;
    push_flags[ST_B] = 1'b1;
    push_flags[ST_U] = 1'b1;
  end

  always_comb begin
    addr_o = pc_i;
    rd_o   = 1'b0;
    we_o   = 1'b0;
    case (kind_i)
      AK_PC:   rd_o = 1'b1;
      AK_STK:  begin addr_o = {STACK_PAGE, sp_i};         rd_o = 1'b1; end
      AK_PUSH: begin addr_o = {STACK_PAGE, sp_i};         we_o = 1'b1; end
      AK_POP:  begin addr_o = {STACK_PAGE, sp_i + B_ONE}; rd_o = 1'b1; end
      AK_VLO:  begin addr_o = VEC_ADDR;                   rd_o = 1'b1; end
      AK_VHI:  begin addr_o = VEC_ADDR + W_ONE;           rd_o = 1'b1; end
      AK_PLO:  begin addr_o = ptr_i;                      rd_o = 1'b1; end
      AK_PHI:  begin
        addr_o = {ptr_i[ADDR_W-1:DATA_W], ptr_i[DATA_W-1:0] + B_ONE};
        rd_o   = 1'b1;
      end
      default: ;
    endcase
    if (!busy_i) begin
      rd_o = 1'b0;
      we_o = 1'b0;
    end
  end

  always_comb begin
    case (psel_i)
      PD_PCH:  wdata_o = pc_i[ADDR_W-1:DATA_W];
      PD_PCL:  wdata_o = pc_i[DATA_W-1:0];
      PD_FLG:  wdata_o = push_flags;
      default: wdata_o = acc_i;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && we_o)) else $error("read and write together"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !(rd_o || we_o)) else $error("strobe while idle"); // R2
  AST_WRITE_IN_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> addr_o[ADDR_W-1:DATA_W] == STACK_PAGE) else $error("write off stack page"); // R3
  AST_FLAG_PUSH_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && psel_i == PD_FLG) |-> (wdata_o[ST_B] && wdata_o[ST_U])) else $error("pushed flags lack bits"); // R9
endmodule

// File: rtl/cts_regs.sv
module cts_regs
  import cts_pkg::*;
#(
  parameter int                  DATA_W   = 8,
  parameter logic [2*DATA_W-1:0] RESET_PC = 16'h0400,
  parameter logic [DATA_W-1:0]   RESET_SP = 8'hFD,
  parameter logic [DATA_W-1:0]   RESET_ST = 8'h24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic                done_i,
  input  op_e                 op_i,
  input  logic [STEP_W-1:0]   step_i,
  input  acc_kind_e           kind_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic [2*DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0]   sp_o,
  output logic [DATA_W-1:0]   st_o,
  output logic [2*DATA_W-1:0] ptr_o,
  output logic                acc_we_o,
  output logic                irq_off_o,
  output logic                irq_on_o
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] B_ONE = 1;
  localparam logic [ADDR_W-1:0] W_ONE = 1;

  logic [ADDR_W-1:0] pc_q, pc_d, ptr_q, ptr_d;
  logic [DATA_W-1:0] sp_q, sp_d, st_q, st_d, tmp_q, tmp_d, pulled;
  logic              irq_off_q, irq_on_q, mask_op;

  always_comb begin
    pulled       = rdata_i;
    pulled[ST_B] = 1'b0;
    pulled[ST_U] = 1'b1;
  end

  always_comb begin
    pc_d  = pc_q;
    sp_d  = sp_q;
    st_d  = st_q;
    tmp_d = tmp_q;
    ptr_d = ptr_q;
    if (busy_i) begin
      if (kind_i == AK_PUSH) sp_d = sp_q - B_ONE;
      if (kind_i == AK_POP)  sp_d = sp_q + B_ONE;
      case (op_i)
        OP_CALL: begin
          if (step_i == 3'd0) begin tmp_d = rdata_i; pc_d = pc_q + W_ONE; end
          if (step_i == 3'd4) pc_d = {rdata_i, tmp_q};
        end
        OP_RET: begin
          if (step_i == 3'd2) tmp_d = rdata_i;
          if (step_i == 3'd3) pc_d = {rdata_i, tmp_q};
          if (step_i == 3'd4) pc_d = pc_q + W_ONE;
        end
        OP_RETI: begin
          if (step_i == 3'd2) st_d = pulled;
          if (step_i == 3'd3) tmp_d = rdata_i;
          if (step_i == 3'd4) pc_d = {rdata_i, tmp_q};
        end
        OP_BRK: begin
          if (step_i == 3'd0) pc_d = pc_q + W_ONE;
          if (step_i == 3'd3) st_d[ST_I] = 1'b1;
          if (step_i == 3'd4) tmp_d = rdata_i;
          if (step_i == 3'd5) pc_d = {rdata_i, tmp_q};
        end
        OP_JMPI: begin
          if (step_i == 3'd0) begin ptr_d[DATA_W-1:0] = rdata_i; pc_d = pc_q + W_ONE; end
          if (step_i == 3'd1) begin ptr_d[ADDR_W-1:DATA_W] = rdata_i; pc_d = pc_q + W_ONE; end
          if (step_i == 3'd2) tmp_d = rdata_i;
          if (step_i == 3'd3) pc_d = {rdata_i, tmp_q};
        end
        OP_PULLA: if (step_i == 3'd2) begin
          st_d[ST_N] = rdata_i[DATA_W-1];
          st_d[ST_Z] = (rdata_i == '0);
        end
        OP_PULLF: if (step_i == 3'd2) st_d = pulled;
        OP_SETI:  st_d[ST_I] = 1'b1;
        OP_CLRI:  st_d[ST_I] = 1'b0;
        default: ;
      endcase
    end
  end

  assign mask_op = (op_i == OP_PULLF) || (op_i == OP_SETI) || (op_i == OP_CLRI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= RESET_PC;
      sp_q      <= RESET_SP;
      st_q      <= RESET_ST;
      tmp_q     <= '0;
      ptr_q     <= '0;
      irq_off_q <= 1'b0;
      irq_on_q  <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      sp_q  <= sp_d;
      st_q  <= st_d;
      tmp_q <= tmp_d;
      ptr_q <= ptr_d;
      if (done_i) begin
        irq_off_q <= mask_op && !st_q[ST_I] && st_d[ST_I];
        irq_on_q  <= mask_op && st_q[ST_I] && !st_d[ST_I];
      end
    end
  end

  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign st_o      = st_q;
  assign ptr_o     = ptr_q;
  assign irq_off_o = irq_off_q;
  assign irq_on_o  = irq_on_q;
  assign acc_we_o  = busy_i && (op_i == OP_PULLA) && (step_i == 3'd2);

  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == AK_PUSH) |=> sp_q == $past(sp_q) - B_ONE) else $error("push did not decrement"); // R3
  AST_POP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == AK_POP) |=> sp_q == $past(sp_q) + B_ONE) else $error("pull did not increment"); // R3
  AST_BRK_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_i == OP_BRK) |=> st_q[ST_I]) else $error("break left mask clear"); // R7
  AST_MARK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_off_q && irq_on_q)) else $error("both markers high"); // R11
  AST_RSVD_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[ST_U] && !st_q[ST_B]) else $error("reserved status bits wrong"); // R9
  AST_MARK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ($stable(irq_off_q) && $stable(irq_on_q))) else $error("marker moved mid-instruction"); // R11
endmodule

// File: rtl/cts_seq_top.sv
module cts_seq_top
  import cts_pkg::*;
#(
  parameter int            DATA_W     = 8,
  parameter logic [7:0]    STACK_PAGE = 8'h01,
  parameter logic [15:0]   RESET_PC   = 16'h0400,
  parameter logic [7:0]    RESET_SP   = 8'hFD,
  parameter logic [7:0]    RESET_ST   = 8'h24,
  parameter logic [15:0]   VEC_ADDR   = 16'hFFFE
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [3:0]  op_i,
  input  logic [7:0]  acc_i,
  input  logic [7:0]  rdata_i,
  output logic [15:0] addr_o,
  output logic        rd_o,
  output logic        we_o,
  output logic [7:0]  wdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  acc_o,
  output logic        acc_we_o,
  output logic [15:0] pc_o,
  output logic [7:0]  sp_o,
  output logic [7:0]  status_o,
  output logic        irq_off_o,
  output logic        irq_on_o
);
  op_e               op_q;
  logic [STEP_W-1:0] step;
  acc_kind_e         kind;
  push_sel_e         psel;
  logic [15:0]       ptr;

  cts_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_e'(op_i)),
    .busy_o  (busy_o),
    .op_o    (op_q),
    .step_o  (step),
    .done_o  (done_o),
    .kind_o  (kind),
    .psel_o  (psel)
  );

  cts_agu #(
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .VEC_ADDR   (VEC_ADDR)
  ) i_agu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy_o),
    .kind_i  (kind),
    .psel_i  (psel),
    .pc_i    (pc_o),
    .sp_i    (sp_o),
    .ptr_i   (ptr),
    .acc_i   (acc_i),
    .st_i    (status_o),
    .addr_o  (addr_o),
    .rd_o    (rd_o),
    .we_o    (we_o),
    .wdata_o (wdata_o)
  );

  cts_regs #(
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC),
    .RESET_SP (RESET_SP),
    .RESET_ST (RESET_ST)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_o),
    .done_i    (done_o),
    .op_i      (op_q),
    .step_i    (step),
    .kind_i    (kind),
    .rdata_i   (rdata_i),
    .pc_o      (pc_o),
    .sp_o      (sp_o),
    .st_o      (status_o),
    .ptr_o     (ptr),
    .acc_we_o  (acc_we_o),
    .irq_off_o (irq_off_o),
    .irq_on_o  (irq_on_o)
  );

  assign acc_o = rdata_i;
endmodule

// File: tb/test_cts_seq_top.sv
`timescale 1ns/100ps
module test_cts_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [7:0]  acc_in = '0;
  logic [7:0]  rdata;
  logic [15:0] addr, pc;
  logic        rd, we, busy, done, acc_we, irq_off, irq_on;
  logic [7:0]  wdata, acc_out, sp, status;
  logic [7:0]  mem [4096];
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;
  assign rdata = mem[addr[11:0]];

  cts_seq_top i_cts_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .acc_i(acc_in),
    .rdata_i(rdata), .addr_o(addr), .rd_o(rd), .we_o(we), .wdata_o(wdata),
    .busy_o(busy), .done_o(done), .acc_o(acc_out), .acc_we_o(acc_we),
    .pc_o(pc), .sp_o(sp), .status_o(status), .irq_off_o(irq_off), .irq_on_o(irq_on)
  );

  function automatic logic [25:0] rdc(logic [15:0] a);
    return {2'b10, a, 8'h00};
  endfunction
  function automatic logic [25:0] wrc(logic [15:0] a, logic [7:0] d);
    return {2'b01, a, d};
  endfunction

  // {op, acc, cycles, pc, sp, status, {irq_off, irq_on}}
  localparam logic [49:0] VEC [16] = '{
    {4'd0, 8'h00, 4'd5, 16'h1234, 8'hFB, 8'h24, 2'b00},
    {4'd1, 8'h00, 4'd5, 16'h0402, 8'hFD, 8'h24, 2'b00},
    {4'd6, 8'h00, 4'd2, 16'h0402, 8'hFC, 8'h24, 2'b00},
    {4'd10,8'h00, 4'd1, 16'h0402, 8'hFC, 8'h20, 2'b01},
    {4'd8, 8'h00, 4'd3, 16'h0402, 8'hFD, 8'h24, 2'b10},
    {4'd5, 8'h80, 4'd2, 16'h0402, 8'hFC, 8'h24, 2'b00},
    {4'd7, 8'h80, 4'd3, 16'h0402, 8'hFD, 8'hA4, 2'b00},
    {4'd5, 8'hDB, 4'd2, 16'h0402, 8'hFC, 8'hA4, 2'b00},
    {4'd8, 8'h00, 4'd3, 16'h0402, 8'hFD, 8'hEB, 2'b01},
    {4'd3, 8'h00, 4'd6, 16'h0600, 8'hFA, 8'hEF, 2'b00},
    {4'd2, 8'h00, 4'd5, 16'h0403, 8'hFD, 8'hEB, 2'b00},
    {4'd4, 8'h00, 4'd4, 16'h0578, 8'hFD, 8'hEB, 2'b00},
    {4'd4, 8'h00, 4'd4, 16'h0400, 8'hFD, 8'hEB, 2'b00},
    {4'd5, 8'h00, 4'd2, 16'h0400, 8'hFC, 8'hEB, 2'b00},
    {4'd7, 8'h00, 4'd3, 16'h0400, 8'hFD, 8'h6B, 2'b00},
    {4'd9, 8'h00, 4'd1, 16'h0400, 8'hFD, 8'h6F, 2'b10}
  };

  localparam logic [25:0] TRC [51] = '{
    rdc(16'h0400), rdc(16'h01FD), wrc(16'h01FD, 8'h04), wrc(16'h01FC, 8'h01), rdc(16'h0401),
    rdc(16'h1234), rdc(16'h01FB), rdc(16'h01FC), rdc(16'h01FD), rdc(16'h0401),
    rdc(16'h0402), wrc(16'h01FD, 8'h34),
    rdc(16'h0402),
    rdc(16'h0402), rdc(16'h01FC), rdc(16'h01FD),
    rdc(16'h0402), wrc(16'h01FD, 8'h80),
    rdc(16'h0402), rdc(16'h01FC), rdc(16'h01FD),
    rdc(16'h0402), wrc(16'h01FD, 8'hDB),
    rdc(16'h0402), rdc(16'h01FC), rdc(16'h01FD),
    rdc(16'h0402), wrc(16'h01FD, 8'h04), wrc(16'h01FC, 8'h03), wrc(16'h01FB, 8'hFB),
    rdc(16'hFFFE), rdc(16'hFFFF),
    rdc(16'h0600), rdc(16'h01FA), rdc(16'h01FB), rdc(16'h01FC), rdc(16'h01FD),
    rdc(16'h0403), rdc(16'h0404), rdc(16'h03FF), rdc(16'h0300),
    rdc(16'h0578), rdc(16'h0579), rdc(16'h0310), rdc(16'h0311),
    rdc(16'h0400), wrc(16'h01FD, 8'h00),
    rdc(16'h0400), rdc(16'h01FC), rdc(16'h01FD),
    rdc(16'h0400)
  };

  function automatic string req_of(logic [3:0] o);
    case (o)
      4'd0: return "R4";
      4'd1: return "R5";
      4'd2: return "R6";
      4'd3: return "R7";
      4'd4: return "R8";
      4'd5: return "R3";
      4'd6, 4'd8: return "R9";
      4'd7: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ti;
    ti = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[12'h400] = 8'h34; mem[12'h401] = 8'h12;
    mem[12'h403] = 8'hFF; mem[12'h404] = 8'h03;
    mem[12'h3FF] = 8'h78; mem[12'h300] = 8'h05;
    mem[12'h578] = 8'h10; mem[12'h579] = 8'h03;
    mem[12'h310] = 8'h00; mem[12'h311] = 8'h04;
    mem[12'hFFE] = 8'h00; mem[12'hFFF] = 8'h06;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pc == 16'h0400, "R1", "reset pc", 32'(pc), 32'h0400);
    chk(sp == 8'hFD, "R1", "reset sp", 32'(sp), 32'hFD);
    chk(status == 8'h24, "R1", "reset status", 32'(status), 32'h24);
    chk(!busy && !rd && !we, "R1", "reset idle strobes", {29'd0, busy, rd, we}, 32'h0);

    for (int v = 0; v < 16; v++) begin
      logic [49:0] e;
      int cyc;
      bit seen;
      e = VEC[v];
      @(negedge clk);
      start = 1'b1; op = e[49:46]; acc_in = e[45:38];
      @(negedge clk);
      start = 1'b0;
      cyc = 0; seen = 1'b0;
      while (!seen && cyc < 16) begin
        if (ti < 51) begin
          logic [25:0] got;
          got = {rd, we, addr, we ? wdata : 8'h00};
          chk(got == TRC[ti], req_of(e[49:46]), "bus cycle", 32'(got), 32'(TRC[ti]));
          ti++;
        end
        if (we) mem[addr[11:0]] = wdata;
        if (done && e[49:46] == 4'd7)
          chk(acc_we && acc_out == e[45:38], "R10", "pulled accumulator",
              {23'd0, acc_we, acc_out}, {23'd0, 1'b1, e[45:38]});
        seen = done;
        cyc++;
        @(negedge clk);
      end
      chk(cyc == int'(e[37:34]), "R2", "cycle count", 32'(cyc), 32'(e[37:34]));
      chk(pc == e[33:18], req_of(e[49:46]), "final pc", 32'(pc), 32'(e[33:18]));
      chk(sp == e[17:10], "R3", "final sp", 32'(sp), 32'(e[17:10]));
      chk(status == e[9:2], req_of(e[49:46]), "final status", 32'(status), 32'(e[9:2]));
      chk({irq_off, irq_on} == e[1:0], "R11", "mask markers",
          32'({irq_off, irq_on}), 32'(e[1:0]));
    end

    // R12: clear-mask request during a call is ignored
    @(negedge clk);
    start = 1'b1; op = 4'd0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; op = 4'd10;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(pc == 16'h1234, "R12", "call target after ignored start", 32'(pc), 32'h1234);
    chk(!busy && !rd && !we, "R12", "idle after ignored start", {29'd0, busy, rd, we}, 32'h0);
    chk(status == 8'h6F, "R12", "mask kept", 32'(status), 32'h6F);
    chk(sp == 8'hFB, "R12", "stack after call", 32'(sp), 32'hFB);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule